// File: doc/BRIEF.md
# Tree-Topology Bus Arbitration Node

This block is the arbitration engine of one node on a half-duplex serial bus whose cable links have already been arranged into a tree. One port leads toward the root (the upstream port) and the others lead toward children (downstream ports). Each line carries one abstract symbol per clock: idle, request, deny, grant or data prefix. A request from a child or from the node's own link is passed upstream. The root settles the contest by granting the first request it sees. Deny and grant symbols travel back down, and the winner then turns its request into a data prefix so that every node along the way is set to repeat the packet.

Fairness rests on a per-node enable flag. A win by an ordinary (asynchronous) local request clears the flag. The flag is set again only when the lines have stayed silent for a full arbitration reset gap. The gap lengths are parameters counted in local clock cycles. An idle counter measures them, and any line activity or any non-idle arbitration state restarts that counter. Isochronous local requests do not depend on the flag or on the gaps.

The controller has seven states. IDLE has no arbitration in progress. LREQ sends the local request upstream. FWD forwards a child's request upstream. GRANT gives the bus to a child. RELAY_UP repeats a child's packet. RELAY_DN repeats traffic or a deny from upstream. SEND covers the local link's transmission. The transitions are:
- IDLE→RELAY_DN when upstream shows deny or prefix (non-root only).
- IDLE→FWD (non-root) or IDLE→GRANT (root) when a child requests.
- IDLE→LREQ (non-root) or IDLE→SEND (root) when a local request is accepted.
- LREQ→SEND on an upstream grant, and LREQ→RELAY_DN on an upstream deny or prefix.
- FWD→GRANT on an upstream grant, FWD→RELAY_DN on an upstream deny or prefix, and FWD→IDLE if the child withdraws.
- GRANT→RELAY_UP on a prefix from the granted child, and GRANT→IDLE if that child goes quiet.
- RELAY_UP→IDLE when the child goes quiet, RELAY_DN→IDLE when upstream goes idle, and SEND→IDLE on link done.

Top module: `tree_arb_node`

## Requirements
- R1: Symbols are 3-bit codes: idle=0, request=1, deny=2, grant=3, prefix=4. After reset every transmitted symbol is idle, `fair_en` is 1, and `loc_won` and `loc_lost` are 0.
- R2: A non-root node with an accepted local request sends request upstream and deny on every downstream port.
- R3: A non-root node that sees request on a downstream port forwards request upstream, sends idle to that child and sends deny to all other children.
- R4: When several children request in the same cycle, the lowest-numbered downstream port is served. At the root, a child request in the same cycle as a local request takes precedence.
- R5: The root answers a child request on the next cycle with grant to that child and deny to the other children. The root's upstream output is always idle.
- R6: When upstream answers deny while the node is requesting, the node withdraws its upstream request and sends deny on all downstream ports, including the child that asked. If the request was local, `loc_won` stays 0 and `loc_lost` pulses for one cycle.
- R7: When upstream grants a local request, `loc_won` pulses for one cycle, and prefix is sent upstream (non-root) and on all downstream ports until `loc_done`.
- R8: When upstream grants a forwarded child request, the node sends grant to that child and idle upstream.
- R9: A prefix arriving on the granted child's port withdraws the grant on the next cycle. The prefix is then repeated upstream (non-root) and on the other children until that child's port is idle.
- R10: A local asynchronous win clears `fair_en`. While `fair_en` is 0, `loc_req` starts no request.
- R11: `fair_en` is set again only after ARB_GAP consecutive quiet cycles. Any line activity or arbitration in progress restarts the count.
- R12: `loc_iso` is accepted regardless of `fair_en` and of gap length, and winning with it leaves `fair_en` unchanged.
- R13: A local asynchronous request is not started until SUB_GAP quiet cycles have elapsed since the last activity or reset.
- R14: At the root, an accepted local request wins on the next cycle with no upstream exchange, and prefix is sent on all downstream ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Active-low reset |
| node_is_root | input | 1 | Node is the tree root (from topology setup) |
| up_rx | input | 3 | Symbol received on the upstream port |
| up_tx | output | 3 | Symbol sent on the upstream port |
| dn_rx | input | 3*NCH | Symbols received on the downstream ports, port i at bits 3i+2:3i |
| dn_tx | output | 3*NCH | Symbols sent on the downstream ports, same packing |
| loc_req | input | 1 | Asynchronous request from the local link, held until won or lost |
| loc_iso | input | 1 | Isochronous request from the local link |
| loc_done | input | 1 | Local packet finished |
| loc_won | output | 1 | One-cycle pulse: local request won |
| loc_lost | output | 1 | One-cycle pulse: local request denied |
| fair_en | output | 1 | Fairness enable flag |

## Verification
The assertions assume a well-behaved neighbourhood: a child never sends prefix unless it has been granted, a parent only sends grant in answer to a request, and `node_is_root` stays fixed between resets. The directed tasks follow these rules. They reset before each change of root role, raise child requests only while the node is idle, and switch a child from request to prefix only after the grant has been observed. Upstream grants and denies are applied only while a request is visible on `up_tx`.

// File: rtl/tarb_pkg.sv
package tarb_pkg;
    localparam int SW = 3;

    typedef enum logic [SW-1:0] {
        SYM_IDLE   = 3'd0,
        SYM_REQ    = 3'd1,
        SYM_DENY   = 3'd2,
        SYM_GRANT  = 3'd3,
        SYM_PREFIX = 3'd4
    } sym_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LREQ,
        ST_FWD,
        ST_GRANT,
        ST_RELAY_UP,
        ST_RELAY_DN,
        ST_SEND
    } arb_state_t;
endpackage

// File: rtl/tarb_idle_timer.sv
module tarb_idle_timer #(
    parameter int SUB_GAP = 16,
    parameter int ARB_GAP = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_active,
    output logic sub_ok,
    output logic arb_gap
);
    localparam int CW = $clog2(ARB_GAP + 1);
    localparam logic [CW-1:0] SUB_LIM = CW'(SUB_GAP);
    localparam logic [CW-1:0] ARB_LIM = CW'(ARB_GAP);
    localparam logic [CW-1:0] ARB_PRE = CW'(ARB_GAP - 1);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
            arb_gap   <= 1'b0;
        end else if (line_active) begin
            quiet_cnt <= '0;
            arb_gap   <= 1'b0;
        end else if (quiet_cnt != ARB_LIM) begin
            quiet_cnt <= quiet_cnt + CW'(1);
            arb_gap   <= (quiet_cnt == ARB_PRE);
        end else begin
            arb_gap   <= 1'b0;
        end
    end

    assign sub_ok = (quiet_cnt >= SUB_LIM);

    // R11: a reset gap is only reported after a quiet cycle
    a_r11_gap_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        arb_gap |-> $past(!line_active));

    // R11: activity restarts the count, so no gap report follows it
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        line_active |=> !arb_gap);
endmodule

// File: rtl/tarb_child_pick.sv
module tarb_child_pick #(
    parameter int NCH = 3,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [IW-1:0]  idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tarb_ctrl.sv
module tarb_ctrl
    import tarb_pkg::*;
#(
    parameter int NCH = 3,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_root,
    input  logic [SW-1:0]    up_sym,
    input  logic [NCH-1:0]   ch_req,
    input  logic [NCH-1:0]   ch_pfx,
    input  logic [NCH-1:0]   ch_quiet,
    input  logic             pick_any,
    input  logic [IW-1:0]    pick_idx,
    input  logic             lreq,
    input  logic             liso,
    input  logic             ldone,
    input  logic             sub_ok,
    input  logic             arb_gap,
    output logic [SW-1:0]    up_out,
    output logic [NCH*SW-1:0] ch_out,
    output logic             busy,
    output logic             won,
    output logic             lost,
    output logic             fair
);
    arb_state_t state, nstate;
    logic [IW-1:0] w_q, w_d;
    logic          iso_q, iso_d;
    logic          won_d, lost_d;
    logic          up_stop, up_grant, local_ok;

    assign up_stop  = !is_root && ((sym_t'(up_sym) == SYM_DENY) || (sym_t'(up_sym) == SYM_PREFIX));
    assign up_grant = !is_root && (sym_t'(up_sym) == SYM_GRANT);
    assign local_ok = liso || (lreq && fair && sub_ok);

    // next-state decision
    always_comb begin
        nstate = state;
        w_d    = w_q;
        iso_d  = iso_q;
        won_d  = 1'b0;
        lost_d = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (up_stop) begin
                    nstate = ST_RELAY_DN;
                end else if (pick_any) begin
                    w_d    = pick_idx;
                    nstate = is_root ? ST_GRANT : ST_FWD;
                end else if (local_ok) begin
                    iso_d = liso;
                    if (is_root) begin
                        nstate = ST_SEND;
                        won_d  = 1'b1;
                    end else begin
                        nstate = ST_LREQ;
                    end
                end
            end
            ST_LREQ: begin
                if (up_grant) begin
                    nstate = ST_SEND;
                    won_d  = 1'b1;
                end else if (up_stop) begin
                    nstate = ST_RELAY_DN;
                    lost_d = 1'b1;
                end
            end
            ST_FWD: begin
                if (up_grant)               nstate = ST_GRANT;
                else if (up_stop)           nstate = ST_RELAY_DN;
                else if (!ch_req[w_q])      nstate = ST_IDLE;
            end
            ST_GRANT: begin
                if (ch_pfx[w_q])            nstate = ST_RELAY_UP;
                else if (ch_quiet[w_q])     nstate = ST_IDLE;
            end
            ST_RELAY_UP: begin
                if (ch_quiet[w_q])          nstate = ST_IDLE;
            end
            ST_RELAY_DN: begin
                if (sym_t'(up_sym) == SYM_IDLE || is_root) nstate = ST_IDLE;
            end
            ST_SEND: begin
                if (ldone)                  nstate = ST_IDLE;
            end
            default:                        nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            w_q   <= '0;
            iso_q <= 1'b0;
            won   <= 1'b0;
            lost  <= 1'b0;
        end else begin
            state <= nstate;
            w_q   <= w_d;
            iso_q <= iso_d;
            won   <= won_d;
            lost  <= lost_d;
        end
    end

    // fairness flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    fair <= 1'b1;
        else if (arb_gap)              fair <= 1'b1;
        else if (won_d && !iso_d)      fair <= 1'b0;
    end

    // outputs
    always_comb begin
        sym_t up_v;
        up_v   = SYM_IDLE;
        ch_out = '0;
        unique case (state)
            ST_IDLE: ;
            ST_LREQ: begin
                up_v = SYM_REQ;
                for (int i = 0; i < NCH; i++) ch_out[i*SW +: SW] = SYM_DENY;
            end
            ST_FWD: begin
                up_v = SYM_REQ;
                for (int i = 0; i < NCH; i++)
                    ch_out[i*SW +: SW] = (IW'(i) == w_q) ? SYM_IDLE : SYM_DENY;
            end
            ST_GRANT: begin
                for (int i = 0; i < NCH; i++)
                    ch_out[i*SW +: SW] = (IW'(i) == w_q) ? SYM_GRANT : SYM_DENY;
            end
            ST_RELAY_UP: begin
                up_v = SYM_PREFIX;
                for (int i = 0; i < NCH; i++)
                    ch_out[i*SW +: SW] = (IW'(i) == w_q) ? SYM_IDLE : SYM_PREFIX;
            end
            ST_RELAY_DN: begin
                for (int i = 0; i < NCH; i++) ch_out[i*SW +: SW] = SYM_DENY;
            end
            ST_SEND: begin
                up_v = SYM_PREFIX;
                for (int i = 0; i < NCH; i++) ch_out[i*SW +: SW] = SYM_PREFIX;
            end
            default: ;
        endcase
        up_out = is_root ? SYM_IDLE : up_v;
    end

    assign busy = (state != ST_IDLE);

    logic [NCH-1:0] grant_vec;
    for (genvar g = 0; g < NCH; g++) begin : g_gv
        assign grant_vec[g] = (ch_out[g*SW +: SW] == SYM_GRANT);
    end

    // R5: at most one downstream port holds a grant
    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R5: the root never drives its upstream port
    a_r5_root_silent_up: assert property (@(posedge clk) disable iff (!rst_n)
        is_root |-> (up_out == SYM_IDLE));

    // R9: a prefix from the granted child pulls the grant on the next cycle
    a_r9_grant_pulled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRANT && ch_pfx[w_q]) |=> (grant_vec == '0));

    // R10: an asynchronous win leaves the flag clear
    a_r10_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (won && !iso_q) |-> !fair);

    // R10: with the flag clear, an asynchronous request starts nothing
    a_r10_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !fair && !liso) |=> (state != ST_LREQ && state != ST_SEND));

    // R6: a request cannot both win and lose
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(won && lost));
endmodule

// File: rtl/tree_arb_node.sv
module tree_arb_node
    import tarb_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int SUB_GAP = 16,
    parameter int ARB_GAP = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             node_is_root,
    input  logic [2:0]       up_rx,
    output logic [2:0]       up_tx,
    input  logic [3*NCH-1:0] dn_rx,
    output logic [3*NCH-1:0] dn_tx,
    input  logic             loc_req,
    input  logic             loc_iso,
    input  logic             loc_done,
    output logic             loc_won,
    output logic             loc_lost,
    output logic             fair_en
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] ch_req, ch_pfx, ch_quiet;
    logic           pick_any;
    logic [IW-1:0]  pick_idx;
    logic           busy, sub_ok, arb_gap, line_active;

    for (genvar p = 0; p < NCH; p++) begin : g_port
        assign ch_req[p]   = (dn_rx[p*SW +: SW] == SYM_REQ);
        assign ch_pfx[p]   = (dn_rx[p*SW +: SW] == SYM_PREFIX);
        assign ch_quiet[p] = (dn_rx[p*SW +: SW] == SYM_IDLE);
    end

    assign line_active = busy || (up_rx != SYM_IDLE) || !(&ch_quiet);

    tarb_child_pick #(.NCH(NCH)) u_pick (
        .req (ch_req),
        .any (pick_any),
        .idx (pick_idx)
    );

    tarb_idle_timer #(.SUB_GAP(SUB_GAP), .ARB_GAP(ARB_GAP)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_active (line_active),
        .sub_ok      (sub_ok),
        .arb_gap     (arb_gap)
    );

    tarb_ctrl #(.NCH(NCH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_root  (node_is_root),
        .up_sym   (up_rx),
        .ch_req   (ch_req),
        .ch_pfx   (ch_pfx),
        .ch_quiet (ch_quiet),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .lreq     (loc_req),
        .liso     (loc_iso),
        .ldone    (loc_done),
        .sub_ok   (sub_ok),
        .arb_gap  (arb_gap),
        .up_out   (up_tx),
        .ch_out   (dn_tx),
        .busy     (busy),
        .won      (loc_won),
        .lost     (loc_lost),
        .fair     (fair_en)
    );
endmodule

// File: tb/sim_tree_arb_node.sv
module sim_tree_arb_node;
    localparam int NCH = 3;
    localparam int SUB = 16;
    localparam int ARB = 40;
    localparam logic [2:0] I = 3'd0, RQ = 3'd1, DN = 3'd2, GR = 3'd3, PF = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic root = 1'b0;
    logic [2:0] up_rx = I;
    logic [2:0] up_tx;
    logic [3*NCH-1:0] dn_rx = '0;
    logic [3*NCH-1:0] dn_tx;
    logic lreq = 1'b0, liso = 1'b0, ldone = 1'b0;
    logic won, lost, fair;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tree_arb_node #(.NCH(NCH), .SUB_GAP(SUB), .ARB_GAP(ARB)) u0 (
        .clk(clk), .rst_n(rst_n), .node_is_root(root),
        .up_rx(up_rx), .up_tx(up_tx), .dn_rx(dn_rx), .dn_tx(dn_tx),
        .loc_req(lreq), .loc_iso(liso), .loc_done(ldone),
        .loc_won(won), .loc_lost(lost), .fair_en(fair)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] dtx(input int i);
        return dn_tx[3*i +: 3];
    endfunction

    task automatic set_dn(input int i, input logic [2:0] s);
        dn_rx[3*i +: 3] = s;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic r);
        @(negedge clk);
        rst_n = 1'b0; root = r; up_rx = I; dn_rx = '0;
        lreq = 0; liso = 0; ldone = 0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 up_tx idle", up_tx, I);
        chk("R1 dn_tx idle", dn_tx, 0);
        chk("R1 fair_en set", fair, 1);
        chk("R1 won clear", won, 0);
        chk("R1 lost clear", lost, 0);
    endtask

    task automatic t_local_async();
        do_reset(1'b0);
        lreq = 1;
        cyc(3);
        chk("R13 no request before sub gap", up_tx, I);
        cyc(SUB + 2);
        chk("R2 request upstream", up_tx, RQ);
        for (int i = 0; i < NCH; i++) chk("R2 deny downstream", dtx(i), DN);
        up_rx = GR;
        cyc(1);
        chk("R7 won pulse", won, 1);
        chk("R7 prefix upstream", up_tx, PF);
        chk("R7 prefix downstream", dtx(1), PF);
        chk("R10 flag cleared", fair, 0);
        up_rx = I; lreq = 0;
        cyc(3);
        chk("R7 won one cycle", won, 0);
        chk("R7 still sending", up_tx, PF);
        ldone = 1;
        cyc(1);
        ldone = 0;
        chk("R7 send ends", up_tx, I);
        lreq = 1;
        cyc(SUB + 4);
        chk("R10 request ignored", up_tx, I);
        chk("R10 flag still clear", fair, 0);
        cyc(6);
        up_rx = PF;
        cyc(1);
        up_rx = I;
        cyc(30);
        chk("R11 activity restarted gap", fair, 0);
        chk("R11 still no request", up_tx, I);
        cyc(15);
        chk("R11 flag re-armed", fair, 1);
        chk("R11 request after re-arm", up_tx, RQ);
        up_rx = DN;
        cyc(1);
        chk("R6 lost pulse", lost, 1);
        chk("R6 won stays low", won, 0);
        chk("R6 request withdrawn", up_tx, I);
        chk("R6 deny downstream", dtx(2), DN);
        up_rx = I; lreq = 0;
        cyc(2);
        chk("R6 lost one cycle", lost, 0);
        chk("R6 back idle", up_tx, I);
    endtask

    task automatic t_child_fwd();
        do_reset(1'b0);
        cyc(4);
        set_dn(1, RQ); set_dn(2, RQ);
        cyc(1);
        chk("R3 forward upstream", up_tx, RQ);
        chk("R4 lowest child served idle", dtx(1), I);
        chk("R3 other child denied", dtx(0), DN);
        chk("R4 higher child denied", dtx(2), DN);
        set_dn(2, I);
        up_rx = GR;
        cyc(1);
        chk("R8 grant to child", dtx(1), GR);
        chk("R8 upstream idle", up_tx, I);
        set_dn(1, PF);
        up_rx = I;
        cyc(1);
        chk("R9 grant withdrawn", dtx(1), I);
        chk("R9 prefix upstream", up_tx, PF);
        chk("R9 prefix to other child", dtx(0), PF);
        cyc(3);
        chk("R9 relay held", dtx(2), PF);
        set_dn(1, I);
        cyc(1);
        chk("R9 relay ends", up_tx, I);
        cyc(4);
        set_dn(0, RQ);
        cyc(1);
        chk("R3 forward child 0", up_tx, RQ);
        up_rx = DN;
        cyc(1);
        chk("R6 deny passed to child", dtx(0), DN);
        chk("R6 forward withdrawn", up_tx, I);
        set_dn(0, I); up_rx = I;
        cyc(2);
    endtask

    task automatic t_root();
        do_reset(1'b1);
        cyc(2);
        set_dn(2, RQ);
        cyc(1);
        chk("R5 grant to child 2", dtx(2), GR);
        chk("R5 deny child 0", dtx(0), DN);
        chk("R5 deny child 1", dtx(1), DN);
        chk("R5 root upstream idle", up_tx, I);
        set_dn(2, PF);
        cyc(1);
        chk("R9 root pulls grant", dtx(2), I);
        chk("R9 root repeats prefix", dtx(0), PF);
        chk("R5 root upstream idle in relay", up_tx, I);
        set_dn(2, I);
        cyc(SUB + 4);
        lreq = 1;
        cyc(1);
        chk("R14 root local wins", won, 1);
        chk("R14 prefix downstream", dtx(1), PF);
        chk("R14 upstream idle", up_tx, I);
        lreq = 0; ldone = 1;
        cyc(1);
        ldone = 0;
        cyc(ARB + 4);
        chk("R11 root flag re-armed", fair, 1);
        lreq = 1; set_dn(0, RQ);
        cyc(1);
        chk("R4 child beats local", dtx(0), GR);
        chk("R4 local not won", won, 0);
        lreq = 0; set_dn(0, I);
        cyc(2);
    endtask

    task automatic t_iso();
        do_reset(1'b0);
        liso = 1;
        cyc(2);
        chk("R12 iso request without gap", up_tx, RQ);
        up_rx = GR;
        cyc(1);
        chk("R12 iso won", won, 1);
        chk("R12 flag kept", fair, 1);
        up_rx = I; liso = 0; ldone = 1;
        cyc(1);
        ldone = 0;
        cyc(2);
        chk("R12 flag kept after send", fair, 1);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_local_async();
        t_child_fwd();
        t_root();
        t_iso();
        summary();
        $finish;
    end
endmodule